// File: doc/BRIEF.md
# Serial Register-Access Slave with Auto-Incrementing Bursts

This block lets an external SPI master read and write a bank of 64 byte-wide registers, and it gives on-chip logic a parallel port to the same bank. The three SPI pins (chip select, serial clock, data in) are brought into the system clock domain through synchronizers. The serial clock is then watched for edges. Timing follows SPI mode 3: the serial clock idles high, data in is sampled on its rising edge and data out changes on its falling edge.

Every transaction begins with an eight-bit header, sent MSB first. The first bit selects the direction. The second bit is a fixed 1. The last six bits are the starting register number. Data bytes follow, MSB first. While chip select stays low, each further byte moves to the next register, and the number wraps from 63 back to 0. A write byte is stored once its eighth bit has been sampled. A read byte is captured from the bank when the byte before it (the header or the previous data byte) completes, and it is then shifted out. Raising chip select ends the transaction and throws away any partial byte.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, all 64 registers read 0 on the parallel port and `spi_miso` is 0.
- R2: The header is taken MSB first. Header bit 7 (the first one sent) is the direction: 1 means read and 0 means write. Header bit 6 is sent as 1. Header bits 5..0 are the register number.
- R3: In a write, the eight bits after the header are stored MSB first into the register named in the header. The byte is stored once its eighth bit has been sampled.
- R4: In a read, `spi_miso` presents the register's bits MSB first. Each bit changes after a falling serial-clock edge and holds steady through the following rising edge, so the first data bit is valid before rising edge 9.
- R5: While chip select stays low, each further byte (read or write) uses the register number one above that of the previous byte.
- R6: A burst that passes register 63 continues at register 0.
- R7: Raising chip select ends the transaction. A write byte with fewer than eight bits is not stored. A header with fewer than eight bits has no effect, and the next transaction starts a new header.
- R8: `spi_miso` is 0 during the header, during a whole write transaction, and while chip select is high.
- R9: `pp_rd_data` shows the register selected by `pp_addr` with no clock delay. A `pp_wr_en` high at a clock edge stores `pp_wr_data` at `pp_addr`.
- R10: A serial write byte is stored on the third system clock edge after the serial clock rises for its last bit (two synchronizer stages plus edge detection). If a parallel write hits the same register on that same edge, the serial byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, 0 when not reading |
| pp_addr | input | 6 | Parallel port register number |
| pp_wr_en | input | 1 | Parallel write strobe |
| pp_wr_data | input | 8 | Parallel write data |
| pp_rd_data | output | 8 | Contents of register `pp_addr` |

## Verification
A serial write commit and a parallel write can land on the same register in the same system clock cycle. To provoke this, the bench holds one serial write to a register fixed and moves a one-cycle parallel write to that register across the second, third and fourth clock edges after the last rising serial-clock edge. The bench's reference model applies each cycle's parallel write first and the due serial commit second. It therefore expects the serial byte to remain after the second and third edges, and the parallel byte after the fourth. The parallel read port is compared with the model on every clock, so the moment of each update is checked as well as the final value.

// File: rtl/spi_regs_pkg.sv
`timescale 1ns/1ps
package spi_regs_pkg;
  localparam int unsigned REG_ADDR_W  = 6;
  localparam int unsigned REG_DATA_W  = 8;
  localparam int unsigned PIN_SYNC_N  = 2;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_HEADER = 2'd1,
    PH_WRITE  = 2'd2,
    PH_READ   = 2'd3
  } phase_e;
endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
  parameter int unsigned N_PINS = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N_PINS-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], pin_i[p]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= {STAGES{RST_VAL[p]}};
      end else begin
        chain_q <= chain_d;
      end
    end

    assign pin_o[p] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_reg_bank.sv
`timescale 1ns/1ps
module spi_reg_bank #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pp_addr,
  input  logic              pp_we,
  input  logic [DATA_W-1:0] pp_wdata,
  output logic [DATA_W-1:0] pp_rdata,
  input  logic [ADDR_W-1:0] ser_raddr,
  output logic [DATA_W-1:0] ser_rdata,
  input  logic              ser_we,
  input  logic [ADDR_W-1:0] ser_waddr,
  input  logic [DATA_W-1:0] ser_wdata
);
  logic [DEPTH*DATA_W-1:0] flat_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              hit_pp;
    logic              hit_ser;
    logic              ent_en;
    logic [DATA_W-1:0] ent_d;
    logic [DATA_W-1:0] ent_q;

    always_comb begin
      hit_pp  = pp_we  && (pp_addr   == ADDR_W'(i));
      hit_ser = ser_we && (ser_waddr == ADDR_W'(i));
      ent_en  = hit_pp || hit_ser;
      ent_d   = ent_q;
      if (hit_pp) begin
        ent_d = pp_wdata;
      end
      if (hit_ser) begin
        ent_d = ser_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_en) begin
        ent_q <= ent_d;
      end
    end

    assign flat_q[i*DATA_W +: DATA_W] = ent_q;
  end

  assign pp_rdata  = flat_q[pp_addr   * DATA_W +: DATA_W];
  assign ser_rdata = flat_q[ser_raddr * DATA_W +: DATA_W];
endmodule

// File: rtl/spi_frame_ctrl.sv
`timescale 1ns/1ps
module spi_frame_ctrl
  import spi_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso,
  output phase_e            phase_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              sclk_q;
  phase_e            phase_q, phase_d, ph_now;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] shin_q, shin_d;
  logic [DATA_W-1:0] shout_q, shout_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              miso_q, miso_d;

  logic              sclk_rise, sclk_fall, last_bit;
  logic [DATA_W-1:0] byte_in;
  logic [ADDR_W-1:0] hdr_addr, step_addr;
  logic              hdr_rd;
  logic              shin_en, shout_en, addr_en;

  always_comb begin
    sclk_rise = sclk_s & ~sclk_q;
    sclk_fall = ~sclk_s & sclk_q;
    last_bit  = (bit_q == BIT_W'(DATA_W-1));
    byte_in   = {shin_q[DATA_W-2:0], mosi_s};
    hdr_addr  = byte_in[ADDR_W-1:0];
    hdr_rd    = shin_q[DATA_W-2];
    step_addr = addr_q + 1'b1;
    ph_now    = (phase_q == PH_IDLE) ? PH_HEADER : phase_q;
    rd_addr   = (ph_now == PH_HEADER) ? hdr_addr : step_addr;
  end

  always_comb begin
    phase_d  = phase_q;
    bit_d    = bit_q;
    shin_d   = shin_q;
    shout_d  = shout_q;
    addr_d   = addr_q;
    miso_d   = miso_q;
    wr_en    = 1'b0;
    shin_en  = 1'b0;
    shout_en = 1'b0;
    addr_en  = 1'b0;
    if (cs_n_s) begin
      phase_d = PH_IDLE;
      bit_d   = '0;
      miso_d  = 1'b0;
    end else begin
      phase_d = ph_now;
      if (sclk_rise) begin
        shin_en = 1'b1;
        shin_d  = byte_in;
        bit_d   = last_bit ? '0 : bit_q + 1'b1;
        if (last_bit) begin
          unique case (ph_now)
            PH_HEADER: begin
              addr_en = 1'b1;
              addr_d  = hdr_addr;
              if (hdr_rd) begin
                phase_d  = PH_READ;
                shout_en = 1'b1;
                shout_d  = rd_data;
              end else begin
                phase_d  = PH_WRITE;
              end
            end
            PH_WRITE: begin
              wr_en   = 1'b1;
              addr_en = 1'b1;
              addr_d  = step_addr;
            end
            PH_READ: begin
              addr_en  = 1'b1;
              addr_d   = step_addr;
              shout_en = 1'b1;
              shout_d  = rd_data;
            end
            default: begin
              phase_d = PH_HEADER;
            end
          endcase
        end
      end else if (sclk_fall && (ph_now == PH_READ)) begin
        miso_d   = shout_q[DATA_W-1];
        shout_en = 1'b1;
        shout_d  = {shout_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b1;
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      miso_q  <= 1'b0;
    end else begin
      sclk_q  <= sclk_s;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      miso_q  <= miso_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shin_q <= '0;
    end else if (shin_en) begin
      shin_q <= shin_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shout_q <= '0;
    end else if (shout_en) begin
      shout_q <= shout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign wr_addr = addr_q;
  assign wr_data = byte_in;
  assign miso    = miso_q;
  assign phase_o = phase_q;
  assign bit_o   = bit_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/spi_reg_slave.sv
`timescale 1ns/1ps
module spi_reg_slave
  import spi_regs_pkg::*;
#(
  parameter int unsigned ADDR_W      = REG_ADDR_W,
  parameter int unsigned DATA_W      = REG_DATA_W,
  parameter int unsigned SYNC_STAGES = PIN_SYNC_N,
  localparam int unsigned BIT_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [ADDR_W-1:0] pp_addr,
  input  logic              pp_wr_en,
  input  logic [DATA_W-1:0] pp_wr_data,
  output logic [DATA_W-1:0] pp_rd_data
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] ser_rd_addr;
  logic [DATA_W-1:0] ser_rd_data;
  logic              ser_wr_en;
  logic [ADDR_W-1:0] ser_wr_addr;
  logic [DATA_W-1:0] ser_wr_data;
  phase_e            ctrl_phase;
  logic [BIT_W-1:0]  ctrl_bit;
  logic [ADDR_W-1:0] ctrl_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  spi_pin_sync #(
    .N_PINS (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b011)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .pin_i({spi_mosi, spi_sclk, spi_cs_n}),
    .pin_o(pins_s)
  );

  spi_frame_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cs_n_s (pins_s[0]),
    .sclk_s (pins_s[1]),
    .mosi_s (pins_s[2]),
    .rd_data(ser_rd_data),
    .rd_addr(ser_rd_addr),
    .wr_en  (ser_wr_en),
    .wr_addr(ser_wr_addr),
    .wr_data(ser_wr_data),
    .miso   (spi_miso),
    .phase_o(ctrl_phase),
    .bit_o  (ctrl_bit),
    .addr_o (ctrl_addr)
  );

  spi_reg_bank #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pp_addr  (pp_addr),
    .pp_we    (pp_wr_en),
    .pp_wdata (pp_wr_data),
    .pp_rdata (pp_rd_data),
    .ser_raddr(ser_rd_addr),
    .ser_rdata(ser_rd_data),
    .ser_we   (ser_wr_en),
    .ser_waddr(ser_wr_addr),
    .ser_wdata(ser_wr_data)
  );
endmodule

// File: rtl/spi_reg_slave_chk.sv
`timescale 1ns/1ps
module spi_reg_slave_chk
  import spi_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned BIT_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              spi_cs_n,
  input logic              spi_miso,
  input logic [ADDR_W-1:0] pp_addr,
  input logic              pp_wr_en,
  input logic [DATA_W-1:0] pp_wr_data,
  input logic [DATA_W-1:0] pp_rd_data,
  input logic              ser_wr_en,
  input logic [ADDR_W-1:0] ser_wr_addr,
  input logic [DATA_W-1:0] ser_wr_data,
  input phase_e            ctrl_phase,
  input logic [BIT_W-1:0]  ctrl_bit,
  input logic [ADDR_W-1:0] ctrl_addr
);
  // R7: a settled high chip select leaves the framer idle with a cleared bit count
  a_r7_deselect_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> (ctrl_phase == PH_IDLE && ctrl_bit == '0));

  // R8: a settled high chip select keeps the serial output low
  a_r8_miso_deselected: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> !spi_miso);

  // R8: the serial output stays low through a write transaction
  a_r8_write_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_phase == PH_WRITE) |-> !spi_miso);

  // R3: a serial store is a single-cycle event per byte
  a_r3_single_commit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ser_wr_en |=> !ser_wr_en);

  // R5, R6: each stored byte moves the burst pointer up by one, modulo the bank size
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ser_wr_en |=> (ctrl_addr == ADDR_W'($past(ser_wr_addr) + 1'b1)));

  // R9: an uncontested parallel write is visible on the next cycle
  a_r9_pp_store: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(pp_wr_en) && !($past(ser_wr_en) && ($past(ser_wr_addr) == $past(pp_addr)))
      && (pp_addr == $past(pp_addr)))
      |-> (pp_rd_data == $past(pp_wr_data)));

  // R10: on a same-register collision the serial byte is kept
  a_r10_serial_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(ser_wr_en) && $past(pp_wr_en) && ($past(ser_wr_addr) == $past(pp_addr))
      && (pp_addr == $past(pp_addr)))
      |-> (pp_rd_data == $past(ser_wr_data)));
endmodule

bind spi_reg_slave spi_reg_slave_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .spi_cs_n   (spi_cs_n),
  .spi_miso   (spi_miso),
  .pp_addr    (pp_addr),
  .pp_wr_en   (pp_wr_en),
  .pp_wr_data (pp_wr_data),
  .pp_rd_data (pp_rd_data),
  .ser_wr_en  (ser_wr_en),
  .ser_wr_addr(ser_wr_addr),
  .ser_wr_data(ser_wr_data),
  .ctrl_phase (ctrl_phase),
  .ctrl_bit   (ctrl_bit),
  .ctrl_addr  (ctrl_addr)
);

// File: tb/spi_reg_slave_bench.sv
`timescale 1ns/1ps
module spi_reg_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WATCHDOG   = 150000;

  logic       clk;
  logic       rst_n;
  logic       cs_n;
  logic       sclk;
  logic       mosi;
  logic       miso;
  logic [5:0] pp_addr;
  logic       pp_wr_en;
  logic [7:0] pp_wr_data;
  logic [7:0] pp_rd_data;

  spi_reg_slave u_spi_reg_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (cs_n),
    .spi_sclk  (sclk),
    .spi_mosi  (mosi),
    .spi_miso  (miso),
    .pp_addr   (pp_addr),
    .pp_wr_en  (pp_wr_en),
    .pp_wr_data(pp_wr_data),
    .pp_rd_data(pp_rd_data)
  );

  int         n_cmp;
  int         n_bad;
  int         cyc;
  bit         run_cmp;
  bit         finished;
  string      cmp_tag;
  logic [7:0] model [64];
  logic [7:0] wq [$];
  int         ser_cnt;
  logic [5:0] ser_a;
  logic [7:0] ser_d;
  int         coll_off;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // Reference model: the parallel write of a cycle lands first, a due serial byte second (R9, R10)
  always @(posedge clk) begin
    if (rst_n && pp_wr_en) model[pp_addr] = pp_wr_data;
    if (ser_cnt > 0) begin
      ser_cnt = ser_cnt - 1;
      if (ser_cnt == 0) model[ser_a] = ser_d;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Compared on every clock: the parallel read port against the model
  always begin
    @(negedge clk);
    #1;
    if (run_cmp && !finished) check(cmp_tag, pp_rd_data, model[pp_addr]);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual=%0d cycles expected=<%0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, input logic exp_miso, input string req,
                         input bit last_wr, input logic [5:0] wa, input logic [7:0] wd);
    sclk = 1'b0;
    mosi = b;
    half_wait();
    check(req, {7'd0, miso}, {7'd0, exp_miso});
    sclk = 1'b1;
    if (last_wr) begin
      ser_a   = wa;
      ser_d   = wd;
      ser_cnt = 3;
    end
    for (int t = 0; t < HALF; t++) begin
      pp_wr_en = (last_wr && coll_off > 0 && t == coll_off - 1);
      @(negedge clk);
    end
    pp_wr_en = 1'b0;
  endtask

  task automatic spi_xfer(input bit rd, input logic [5:0] a, input int nbytes,
                          input int tail, input string req);
    logic [5:0] cur;
    logic [7:0] hdr;
    cur = a;
    hdr = {rd, 1'b1, a};
    cs_n = 1'b0;
    half_wait();
    for (int j = 7; j >= 0; j--) spi_bit(hdr[j], 1'b0, "R8", 1'b0, 6'd0, 8'd0);
    for (int k = 0; k < nbytes + ((tail > 0) ? 1 : 0); k++) begin
      logic [7:0] wb;
      int nb;
      wb = rd ? 8'h00 : wq[k];
      nb = (k < nbytes) ? 8 : tail;
      for (int j = 0; j < nb; j++) begin
        spi_bit(wb[7-j], rd ? model[cur][7-j] : 1'b0, rd ? req : "R8",
                (!rd && j == 7), cur, wb);
      end
      cur = cur + 6'd1;
    end
    half_wait();
    cs_n = 1'b1;
    half_wait();
    check("R8", {7'd0, miso}, 8'd0);
    wq.delete();
  endtask

  task automatic header_abort(input logic [7:0] hdr, input int nbits);
    cs_n = 1'b0;
    half_wait();
    for (int j = 7; j > 7 - nbits; j--) spi_bit(hdr[j], 1'b0, "R8", 1'b0, 6'd0, 8'd0);
    half_wait();
    cs_n = 1'b1;
    half_wait();
  endtask

  task automatic pp_write(input logic [5:0] a, input logic [7:0] d);
    pp_addr    = a;
    pp_wr_data = d;
    pp_wr_en   = 1'b1;
    @(negedge clk);
    pp_wr_en   = 1'b0;
    @(negedge clk);
  endtask

  task automatic sweep(input string tag);
    cmp_tag = tag;
    for (int i = 0; i < 64; i++) begin
      pp_addr = 6'(i);
      @(negedge clk);
    end
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0; run_cmp = 0; finished = 0;
    ser_cnt = 0; coll_off = 0; cmp_tag = "R1";
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; mosi = 1'b0;
    pp_addr = '0; pp_wr_en = 1'b0; pp_wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_cmp = 1'b1;

    // R1: reset contents and idle output
    check("R1", {7'd0, miso}, 8'd0);
    sweep("R1");

    // R9: parallel writes, seen on the following cycle and by a sweep
    cmp_tag = "R9";
    pp_write(6'd7, 8'h11);
    pp_write(6'd40, 8'h5A);
    pp_write(6'd63, 8'hC3);
    pp_write(6'd0, 8'h7E);
    sweep("R9");

    // R2, R3: single writes, address bits of alternating patterns
    cmp_tag = "R3"; pp_addr = 6'd5;
    wq.push_back(8'h96);
    spi_xfer(1'b0, 6'd5, 1, 0, "R3");
    cmp_tag = "R2"; pp_addr = 6'h2A;
    wq.push_back(8'h81);
    spi_xfer(1'b0, 6'h2A, 1, 0, "R2");
    pp_addr = 6'h15;
    wq.push_back(8'h3F);
    spi_xfer(1'b0, 6'h15, 1, 0, "R2");

    // R4: single reads of serially and parallel written registers
    spi_xfer(1'b1, 6'd5, 1, 0, "R4");
    spi_xfer(1'b1, 6'd40, 1, 0, "R4");
    spi_xfer(1'b1, 6'h2A, 1, 0, "R4");

    // R5: burst write then burst read
    cmp_tag = "R5"; pp_addr = 6'd12;
    wq.push_back(8'hA1); wq.push_back(8'hB2); wq.push_back(8'hC4); wq.push_back(8'hD8);
    spi_xfer(1'b0, 6'd10, 4, 0, "R5");
    sweep("R5");
    spi_xfer(1'b1, 6'd10, 4, 0, "R5");

    // R6: bursts running past the last register
    cmp_tag = "R6"; pp_addr = 6'd0;
    wq.push_back(8'h1E); wq.push_back(8'h2D); wq.push_back(8'h4B);
    spi_xfer(1'b0, 6'd62, 3, 0, "R6");
    sweep("R6");
    spi_xfer(1'b1, 6'd63, 3, 0, "R6");

    // R7: partial bytes and a cut-short header
    cmp_tag = "R7"; pp_addr = 6'd30;
    wq.push_back(8'hFF);
    spi_xfer(1'b0, 6'd30, 0, 5, "R7");
    pp_addr = 6'd32;
    wq.push_back(8'h5C); wq.push_back(8'hEE);
    spi_xfer(1'b0, 6'd31, 1, 3, "R7");
    header_abort({1'b0, 1'b1, 6'd33}, 4);
    pp_addr = 6'd33;
    wq.push_back(8'h69);
    spi_xfer(1'b0, 6'd33, 1, 0, "R7");
    spi_xfer(1'b1, 6'd31, 3, 0, "R7");

    // R10: parallel write swept across the serial store edge
    cmp_tag = "R10"; pp_addr = 6'd20; pp_wr_data = 8'h3C;
    for (int k = 2; k <= 4; k++) begin
      coll_off = k;
      wq.push_back(8'hA5);
      spi_xfer(1'b0, 6'd20, 1, 0, "R10");
      coll_off = 0;
      repeat (4) @(negedge clk);
    end

    sweep("R9");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule